// File: doc/BRIEF.md
# Posted-Write Parity Error Handler

This block handles data parity errors on posted writes that cross a two-port bus bridge, in both directions. Each accepted data phase is captured. On the next clock it is checked against the even parity bit that the initiator drives one cycle after the data. The word is then passed on to the opposite port, and a bad parity bit travels with it. The write is never aborted. A word that failed its check leaves the block carrying an inverted parity bit, so the far target also sees the error.

The block raises the active-low parity-error output of the initiating side when that side's response enable is set. It records the detection in a sticky status bit whatever the enable says. On the secondary side it also watches the parity-error line driven by the target of a downstream write. The primary system-error output fires only when four separate enables line up.

Each data path is valid/ready. The input accepts a word only when its capture stage is empty and the output register is empty or draining this cycle, so words arrive at most every other clock. An output word is held unchanged while `ready` is low. Configuration bits, error pins and status are plain signals.

Top module: `pw_parity_guard`

## Requirements
- R1: A data phase accepted in cycle T has a parity error when the parity input sampled in cycle T+1 differs from the XOR of its 32 data bits and 4 byte-enable bits (even parity).
- R2: On an error with the side's response enable set, that side's parity-error output is low in cycle T+2 only, one clock per event, and high otherwise.
- R3: With the response enable clear, the parity-error output stays high, but the detected status bit is still set (status bit 0 for primary, bit 1 for secondary).
- R4: A forwarded word keeps its data and byte enables. Its forwarded parity equals the XOR of data and byte enables, inverted when the word failed its check.
- R5: Every accepted word is forwarded in order, errored or not. No word is dropped.
- R6: An input is ready only when its capture stage is empty and its output register is empty or accepted this cycle. While the output is valid and not ready it holds its word and valid.
- R7: Secondary-to-primary writes are handled in the same way, using the secondary response enable, the secondary parity-error output and status bit 1.
- R8: A low target parity-error input on the secondary side sets status bit 2 on the next edge, only if the secondary response enable is set.
- R9: The primary system-error output is low for one clock, and status bit 3 is set, only when the target input was low with the system-error enable set, the posted-write event mask clear, and both response enables set.
- R10: Status bits are sticky. Writing one on the matching clear bit clears a bit, and a set in the same cycle wins over the clear.
- R11: After reset every error output is high, status is zero, and no output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_dp_valid | input | 1 | Primary-side write data phase valid |
| pri_dp_ready | output | 1 | Primary-side input may accept |
| pri_ad | input | 32 | Primary write data |
| pri_cbe | input | 4 | Primary byte enables |
| pri_par | input | 1 | Primary parity, one cycle after data |
| sec_dp_valid | input | 1 | Secondary-side write data phase valid |
| sec_dp_ready | output | 1 | Secondary-side input may accept |
| sec_ad | input | 32 | Secondary write data |
| sec_cbe | input | 4 | Secondary byte enables |
| sec_par | input | 1 | Secondary parity, one cycle after data |
| dn_valid | output | 1 | Word forwarded toward secondary valid |
| dn_ready | input | 1 | Secondary forwarding path accepts |
| dn_ad | output | 32 | Forwarded downstream data |
| dn_cbe | output | 4 | Forwarded downstream byte enables |
| dn_par | output | 1 | Forwarded downstream parity |
| up_valid | output | 1 | Word forwarded toward primary valid |
| up_ready | input | 1 | Primary forwarding path accepts |
| up_ad | output | 32 | Forwarded upstream data |
| up_cbe | output | 4 | Forwarded upstream byte enables |
| up_par | output | 1 | Forwarded upstream parity |
| sec_tgt_perr_n | input | 1 | Parity error from secondary-side target, active low |
| pri_perr_resp_en | input | 1 | Primary parity-error response enable |
| sec_perr_resp_en | input | 1 | Secondary parity-error response enable |
| serr_en | input | 1 | System-error enable |
| pw_serr_mask | input | 1 | Posted-write parity system-error event disable |
| status_clr | input | 4 | Write-one-to-clear strobes for status |
| pri_perr_n | output | 1 | Primary parity-error output, active low |
| sec_perr_n | output | 1 | Secondary parity-error output, active low |
| pri_serr_n | output | 1 | Primary system-error output, active low |
| status | output | 4 | Sticky status bits (0 pri detect, 1 sec detect, 2 target-reported, 3 system error signaled) |

## Verification
The downstream path is driven from a table of words that mixes all-zero, all-one and alternating data with good and flipped parity, and with the response enable both set and clear. This separates a wrong parity computation from wrong gating of the error pin and from wrong status stickiness. A stalled output with a second word waiting shows whether words are held, refused and then delivered in order. The system-error gate is tried with each of its four enables removed in turn, which shows that every condition is really needed. A clear in the same cycle as a set tells apart the priority of set over clear.

// File: rtl/pwpe_pkg.sv
package pwpe_pkg;
  localparam int ST_PRI_DET  = 0;
  localparam int ST_SEC_DET  = 1;
  localparam int ST_SEC_TGT  = 2;
  localparam int ST_SIG_SERR = 3;
  localparam int ST_W        = 4;
endpackage

// File: rtl/pwpe_lane.sv
module pwpe_lane #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_ad,
  input  logic [CW-1:0] in_cbe,
  input  logic          in_par,
  input  logic          resp_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_ad,
  output logic [CW-1:0] out_cbe,
  output logic          out_par,
  output logic          perr_n,
  output logic          det_pulse
);
  localparam int WW = DW + CW;

  logic          cap_v;
  logic [WW-1:0] cap_w;
  logic          o_v;
  logic [WW-1:0] o_w;
  logic          o_poison;
  logic          par_bad;
  logic          take;

  assign in_ready = !cap_v && (!o_v || out_ready);
  assign take     = in_valid && in_ready;
  // parity arrives one clock after the data it covers
  assign par_bad  = cap_v && (in_par != (^cap_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      cap_w    <= '0;
      o_v      <= 1'b0;
      o_w      <= '0;
      o_poison <= 1'b0;
      perr_n   <= 1'b1;
    end else begin
      cap_v <= take;
      if (take) cap_w <= {in_ad, in_cbe};
      if (cap_v) begin
        o_v      <= 1'b1;
        o_w      <= cap_w;
        o_poison <= par_bad;
      end else if (out_ready) begin
        o_v <= 1'b0;
      end
      perr_n <= !(par_bad && resp_en);
    end
  end

  assign out_valid = o_v;
  assign out_ad    = o_w[WW-1:CW];
  assign out_cbe   = o_w[CW-1:0];
  assign out_par   = (^o_w) ^ o_poison;
  assign det_pulse = par_bad;

  // R2: a parity-error pulse always belongs to a poisoned word just loaded
  p_perr_poison_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> (o_v && o_poison && $past(resp_en)));
  // R6: capture stage never holds a word while the output is occupied
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |-> !o_v);
  // R6: stalled output keeps its contents
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_v && !out_ready) |=> (o_v && $stable(o_w) && $stable(o_poison)));
endmodule

// File: rtl/pwpe_serr_gate.sv
module pwpe_serr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_perr_n,
  input  logic serr_en,
  input  logic pw_serr_mask,
  input  logic pri_resp_en,
  input  logic sec_resp_en,
  output logic serr_n,
  output logic dpd_pulse,
  output logic sig_pulse
);
  logic hit;

  assign hit       = !tgt_perr_n;
  assign dpd_pulse = hit && sec_resp_en;
  assign sig_pulse = dpd_pulse && pri_resp_en && serr_en && !pw_serr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) serr_n <= 1'b1;
    else        serr_n <= !sig_pulse;
  end

  // R9: system error only follows a target report with all four enables
  p_serr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> $past(!tgt_perr_n && serr_en && !pw_serr_mask && pri_resp_en && sec_resp_en));
endmodule

// File: rtl/pwpe_status.sv
module pwpe_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] st
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      st[i] <= 1'b0;
      else if (set[i]) st[i] <= 1'b1;
      else if (clr[i]) st[i] <= 1'b0;
    end

    // R10: bit stays set until a clear strobe
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st[i] && !clr[i]) |=> st[i]);
    // R10: set wins over a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> st[i]);
  end
endmodule

// File: rtl/pw_parity_guard.sv
module pw_parity_guard
  import pwpe_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pri_dp_valid,
  output logic            pri_dp_ready,
  input  logic [DW-1:0]   pri_ad,
  input  logic [CW-1:0]   pri_cbe,
  input  logic            pri_par,
  input  logic            sec_dp_valid,
  output logic            sec_dp_ready,
  input  logic [DW-1:0]   sec_ad,
  input  logic [CW-1:0]   sec_cbe,
  input  logic            sec_par,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic [DW-1:0]   dn_ad,
  output logic [CW-1:0]   dn_cbe,
  output logic            dn_par,
  output logic            up_valid,
  input  logic            up_ready,
  output logic [DW-1:0]   up_ad,
  output logic [CW-1:0]   up_cbe,
  output logic            up_par,
  input  logic            sec_tgt_perr_n,
  input  logic            pri_perr_resp_en,
  input  logic            sec_perr_resp_en,
  input  logic            serr_en,
  input  logic            pw_serr_mask,
  input  logic [ST_W-1:0] status_clr,
  output logic            pri_perr_n,
  output logic            sec_perr_n,
  output logic            pri_serr_n,
  output logic [ST_W-1:0] status
);
  logic            pri_det, sec_det, dpd_p, sig_p;
  logic [ST_W-1:0] st_set;

  pwpe_lane #(.DW(DW), .CW(CW)) u_down (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pri_dp_valid), .in_ready(pri_dp_ready),
    .in_ad(pri_ad), .in_cbe(pri_cbe), .in_par(pri_par),
    .resp_en(pri_perr_resp_en),
    .out_valid(dn_valid), .out_ready(dn_ready),
    .out_ad(dn_ad), .out_cbe(dn_cbe), .out_par(dn_par),
    .perr_n(pri_perr_n), .det_pulse(pri_det)
  );

  pwpe_lane #(.DW(DW), .CW(CW)) u_up (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sec_dp_valid), .in_ready(sec_dp_ready),
    .in_ad(sec_ad), .in_cbe(sec_cbe), .in_par(sec_par),
    .resp_en(sec_perr_resp_en),
    .out_valid(up_valid), .out_ready(up_ready),
    .out_ad(up_ad), .out_cbe(up_cbe), .out_par(up_par),
    .perr_n(sec_perr_n), .det_pulse(sec_det)
  );

  pwpe_serr_gate u_serr (
    .clk(clk), .rst_n(rst_n),
    .tgt_perr_n(sec_tgt_perr_n),
    .serr_en(serr_en), .pw_serr_mask(pw_serr_mask),
    .pri_resp_en(pri_perr_resp_en), .sec_resp_en(sec_perr_resp_en),
    .serr_n(pri_serr_n), .dpd_pulse(dpd_p), .sig_pulse(sig_p)
  );

  always_comb begin
    st_set              = '0;
    st_set[ST_PRI_DET]  = pri_det;
    st_set[ST_SEC_DET]  = sec_det;
    st_set[ST_SEC_TGT]  = dpd_p;
    st_set[ST_SIG_SERR] = sig_p;
  end

  pwpe_status #(.N(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(status_clr), .st(status)
  );

  // R3: a detected primary error is recorded whatever the enable
  p_det_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pri_det |=> status[ST_PRI_DET]);
  // R9: system-error pulse is mirrored in status
  p_serr_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> status[ST_SIG_SERR]);
endmodule

// File: tb/pw_parity_guard_test.sv
`timescale 1ns/1ps
module pw_parity_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        pri_dp_valid = 0, sec_dp_valid = 0, dn_ready = 1, up_ready = 1;
  logic        pri_dp_ready, sec_dp_ready;
  logic [31:0] pri_ad = 0, sec_ad = 0, dn_ad, up_ad;
  logic [3:0]  pri_cbe = 0, sec_cbe = 0, dn_cbe, up_cbe;
  logic        pri_par = 0, sec_par = 0, dn_par, up_par, dn_valid, up_valid;
  logic        sec_tgt_perr_n = 1;
  logic        pri_perr_resp_en = 1, sec_perr_resp_en = 1, serr_en = 0, pw_serr_mask = 0;
  logic [3:0]  status_clr = 0, status;
  logic        pri_perr_n, sec_perr_n, pri_serr_n;

  pw_parity_guard uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // {resp_en, flip, cbe, ad}
  localparam logic [37:0] VEC [6] = '{
    {1'b1, 1'b0, 4'hF, 32'h0000_0000},
    {1'b1, 1'b1, 4'h0, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 4'h5, 32'h1234_5678},
    {1'b0, 1'b1, 4'hA, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 4'h3, 32'h8000_0001},
    {1'b0, 1'b0, 4'hC, 32'h0F0F_F0F0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic dn_send(input logic [31:0] ad, input logic [3:0] cbe, input logic flip);
    @(negedge clk); pri_dp_valid = 1; pri_ad = ad; pri_cbe = cbe;
    @(negedge clk); pri_dp_valid = 0; pri_par = (^{ad, cbe}) ^ flip;
    @(negedge clk);
  endtask

  task automatic up_send(input logic [31:0] ad, input logic [3:0] cbe, input logic flip);
    @(negedge clk); sec_dp_valid = 1; sec_ad = ad; sec_cbe = cbe;
    @(negedge clk); sec_dp_valid = 0; sec_par = (^{ad, cbe}) ^ flip;
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); status_clr = 4'hF;
    @(negedge clk); status_clr = 4'h0;
  endtask

  task automatic tgt_case(input logic se, input logic mk, input logic pr, input logic sr,
                          input logic exp_serr, input logic exp_dpd, input string tag);
    @(negedge clk); serr_en = se; pw_serr_mask = mk; pri_perr_resp_en = pr;
    sec_perr_resp_en = sr; sec_tgt_perr_n = 0;
    @(negedge clk); sec_tgt_perr_n = 1;
    check({"R9 serr ", tag}, pri_serr_n, !exp_serr);
    check({"R9 sig status ", tag}, status[3], exp_serr);
    check({"R8 dpd status ", tag}, status[2], exp_dpd);
    @(negedge clk);
    check({"R9 serr single ", tag}, pri_serr_n, 1'b1);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic acc;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 pri_perr_n", pri_perr_n, 1'b1);
    check("R11 sec_perr_n", sec_perr_n, 1'b1);
    check("R11 serr_n", pri_serr_n, 1'b1);
    check("R11 status", status, 4'h0);
    check("R11 dn_valid", dn_valid, 1'b0);
    check("R11 up_valid", up_valid, 1'b0);
    rst_n = 1;

    acc = 0;
    for (int i = 0; i < 6; i++) begin
      logic en, fl; logic [3:0] cb; logic [31:0] ad;
      {en, fl, cb, ad} = VEC[i];
      pri_perr_resp_en = en;
      dn_send(ad, cb, fl);
      acc = acc | fl;
      check("R2/R3 perr at T+2", pri_perr_n, !(fl && en));
      check("R1/R3 pri detect status", status[0], acc);
      check("R4 fwd parity", dn_par, (^{ad, cb}) ^ fl);
      check("R5 fwd valid", dn_valid, 1'b1);
      check("R4 fwd data", {dn_cbe, dn_ad}, {cb, ad});
      @(negedge clk);
      check("R2 perr single cycle", pri_perr_n, 1'b1);
      check("R5 drained", dn_valid, 1'b0);
    end
    check("R7 no cross perr", sec_perr_n, 1'b1);
    clear_all();
    check("R10 clear", status, 4'h0);

    // R7 upstream
    sec_perr_resp_en = 1;
    up_send(32'hA5A5_5A5A, 4'h9, 1'b1);
    check("R7 sec perr", sec_perr_n, 1'b0);
    check("R7 pri perr quiet", pri_perr_n, 1'b1);
    check("R7 sec status", status[1:0], 2'b10);
    check("R7 up parity", up_par, (^{32'hA5A5_5A5A, 4'h9}) ^ 1'b1);
    check("R7 up data", up_ad, 32'hA5A5_5A5A);
    up_send(32'h0000_0007, 4'h1, 1'b0);
    check("R7 good word no perr", sec_perr_n, 1'b1);
    check("R7 good parity", up_par, ^{32'h0000_0007, 4'h1});
    repeat (3) @(negedge clk);
    check("R10 sticky", status[1], 1'b1);
    clear_all();

    // R6 back-pressure and ordering
    dn_ready = 0;
    dn_send(32'h1111_2222, 4'h6, 1'b0);
    check("R6 out valid stalled", dn_valid, 1'b1);
    check("R6 input refused", pri_dp_ready, 1'b0);
    pri_dp_valid = 1; pri_ad = 32'h3333_4444; pri_cbe = 4'h2;
    @(negedge clk);
    @(negedge clk);
    check("R6 hold data", dn_ad, 32'h1111_2222);
    check("R6 hold valid", dn_valid, 1'b1);
    check("R6 still refused", pri_dp_ready, 1'b0);
    dn_ready = 1;
    @(negedge clk);
    pri_dp_valid = 0; pri_par = ^{32'h3333_4444, 4'h2};
    check("R5 gap while capturing", dn_valid, 1'b0);
    @(negedge clk);
    check("R5 second word in order", dn_ad, 32'h3333_4444);
    check("R5 second valid", dn_valid, 1'b1);
    check("R4 second parity", dn_par, ^{32'h3333_4444, 4'h2});
    @(negedge clk);

    // R8 / R9 target-reported errors
    tgt_case(1, 0, 1, 1, 1, 1, "all on");
    tgt_case(0, 0, 1, 1, 0, 1, "serr_en off");
    tgt_case(1, 1, 1, 1, 0, 1, "masked");
    tgt_case(1, 0, 1, 0, 0, 0, "sec resp off");
    tgt_case(1, 0, 0, 1, 0, 1, "pri resp off");

    // R10 set wins over clear
    @(negedge clk); sec_perr_resp_en = 1; serr_en = 0; sec_tgt_perr_n = 0; status_clr = 4'b0100;
    @(negedge clk); sec_tgt_perr_n = 1; status_clr = 0;
    check("R10 set wins", status[2], 1'b1);
    @(negedge clk); status_clr = 4'b0100;
    @(negedge clk); status_clr = 0;
    check("R10 w1c", status[2], 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule